// File: doc/BRIEF.md
# Universal Bidirectional Bus Transceiver Register

This block carries a data word in each direction between two ports, A and B. Each direction has one storage element with three ways of working. It can pass data straight through, hold a value, or capture the input when that direction's strobe rises. Each direction has four control inputs of its own: a transparency enable, a strobe, an active-low strobe enable and an active-low output enable. The two directions share no control.

The design is fully synchronous to one core clock, `clk`. Each direction strobe is an ordinary input. The core clock samples it, and a rising edge is seen when the strobe is high at a core clock edge after being low at the edge before. There are no internal tri-states. Each port gives its data and an active-high drive-enable separately, and the pad ring joins them into tri-state drivers.

Top module: `bidir_xcvr_reg`

## Requirements
- R1: While a direction's transparency enable (`ab_le`/`ba_le`) is 1, that direction's output equals its input in the same cycle. The strobe and strobe-enable levels make no difference.
- R2: A capture happens at a core clock edge where all of these hold: the transparency enable is 0, the strobe enable is 0 (active low), and the strobe is sampled 1 after being sampled 0 at the previous edge. The input at that edge is stored, and it drives the output from that edge on.
- R3: While the transparency enable is 0 and there is no capture, the output keeps its stored value. This holds whether the strobe stays high, stays low or falls.
- R4: While the strobe enable is 1, strobe rises cause no capture and the stored value is held.
- R5: Each core clock edge with the transparency enable at 1 loads the input into storage. After the enable falls, the output shows the input sampled at the last edge where the enable was 1.
- R6: A port's drive-enable (`b_drv` for the A-to-B direction, `a_drv` for B-to-A) is the inverse of that direction's output enable. Captures still happen while the drive is off, and the output enable never changes the stored contents.
- R7: The two directions are independent. The controls and data of one direction never change the storage or output of the other.
- R8: A synchronous active-low reset `rst_n` clears both stored values to 0.
- R9: The data width is set by the parameter `DATA_W`, which defaults to 18 bits in each direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Synchronous active-low reset |
| a_in | input | DATA_W | Data received on port A |
| a_out | output | DATA_W | Data to drive onto port A (B-to-A path) |
| a_drv | output | 1 | Active-high drive enable for port A |
| b_in | input | DATA_W | Data received on port B |
| b_out | output | DATA_W | Data to drive onto port B (A-to-B path) |
| b_drv | output | 1 | Active-high drive enable for port B |
| ab_oe_n | input | 1 | A-to-B output enable, active low |
| ab_le | input | 1 | A-to-B transparency enable |
| ab_strobe | input | 1 | A-to-B capture strobe |
| ab_strobe_en_n | input | 1 | A-to-B strobe enable, active low |
| ba_oe_n | input | 1 | B-to-A output enable, active low |
| ba_le | input | 1 | B-to-A transparency enable |
| ba_strobe | input | 1 | B-to-A capture strobe |
| ba_strobe_en_n | input | 1 | B-to-A strobe enable, active low |

## Verification
The bench builds the block with the default `DATA_W` of 18. The data vectors therefore include the all-ones pattern 0x3FFFF and alternating patterns, which reach every bit of both paths. The same width lets the bench check the port width directly.

The vector table drives one direction through each of these cases:
- capture on a strobe rise;
- a strobe held high or falling;
- a strobe rise with the strobe enable off;
- transparency, and what is left in storage when it ends.

Throughout the table the other direction is held with its data moving, which shows that the two directions are separate. Directed steps then capture while the output drive is off, and run a reset in the middle of operation.

// File: rtl/xcvr_pkg.sv
// Package: shared defaults and the per-direction control bundle.
// Assumes: all control fields are sampled by the single core clock.
package xcvr_pkg;
    localparam int DEFAULT_W = 18;
    localparam int NUM_DIR   = 2;    // index 0: A to B, index 1: B to A

    typedef struct packed {
        logic le;        // transparency enable, active high
        logic strobe;    // capture strobe, rising edge active
        logic stb_en_n;  // strobe enable, active low
        logic oe_n;      // output enable, active low
    } dir_ctl_t;
endpackage

// File: rtl/xcvr_rise_det.sv
// Module: rising-edge detector for a direction strobe, sampled by the core clock.
// Assumes: the strobe is synchronous to clk or already synchronized. The previous
// sample follows the strobe even during reset, so a strobe that is high
// through reset gives no false edge afterwards.
module xcvr_rise_det (
    input  logic clk,
    input  logic sig_in,
    output logic rise
);
    logic prev_q;

    // Purpose: remember the strobe level seen at the previous core clock edge.
    always_ff @(posedge clk) begin
        prev_q <= sig_in;
    end

    // Purpose: flag a low-to-high change between two core clock edges.
    always_comb begin
        rise = sig_in & ~prev_q;
    end
endmodule

// File: rtl/xcvr_lane.sv
// Module: one direction's storage element. It is a register with a transparent
// bypass. The register reloads every cycle while transparent and captures on a
// qualified strobe rise. The drive enable is the inverse of the output enable.
// Assumes: synchronous active-low reset, single core clock.
module xcvr_lane
    import xcvr_pkg::*;
#(
    parameter int W = DEFAULT_W
) (
    input  logic         clk,
    input  logic         rst_n,
    input  dir_ctl_t     ctl,
    input  logic [W-1:0] din,
    output logic [W-1:0] dout,
    output logic         drv
);
    logic [W-1:0] held_q;
    logic         stb_rise;
    logic         capture;

    xcvr_rise_det u_rise (
        .clk    (clk),
        .sig_in (ctl.strobe),
        .rise   (stb_rise)
    );

    // Purpose: qualify a strobe rise with latch mode and the strobe enable.
    always_comb begin
        capture = ~ctl.le & ~ctl.stb_en_n & stb_rise;
    end

    // Purpose: storage update (track while transparent, else capture on a qualified rise).
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            held_q <= '0;
        end else if (ctl.le || capture) begin
            held_q <= din;
        end
    end

    // Purpose: output mux (transparent bypass or stored value) and drive enable.
    always_comb begin
        dout = ctl.le ? din : held_q;
        drv  = ~ctl.oe_n;
    end
endmodule

// File: rtl/bidir_xcvr_reg.sv
// Module: top of the bidirectional transceiver register. It holds one storage
// lane per direction, and each lane has its own control bundle.
// Assumes: tri-state drivers sit outside this block and are built from
// a_out/a_drv and b_out/b_drv.
module bidir_xcvr_reg
    import xcvr_pkg::*;
#(
    parameter int DATA_W = DEFAULT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [DATA_W-1:0] a_in,
    output logic [DATA_W-1:0] a_out,
    output logic              a_drv,
    input  logic [DATA_W-1:0] b_in,
    output logic [DATA_W-1:0] b_out,
    output logic              b_drv,
    input  logic              ab_oe_n,
    input  logic              ab_le,
    input  logic              ab_strobe,
    input  logic              ab_strobe_en_n,
    input  logic              ba_oe_n,
    input  logic              ba_le,
    input  logic              ba_strobe,
    input  logic              ba_strobe_en_n
);
    dir_ctl_t          ctl  [NUM_DIR];
    logic [DATA_W-1:0] src  [NUM_DIR];
    logic [DATA_W-1:0] dst  [NUM_DIR];
    logic              dvr  [NUM_DIR];

    // Purpose: gather each direction's controls and source data.
    always_comb begin
        ctl[0] = '{le: ab_le, strobe: ab_strobe, stb_en_n: ab_strobe_en_n, oe_n: ab_oe_n};
        ctl[1] = '{le: ba_le, strobe: ba_strobe, stb_en_n: ba_strobe_en_n, oe_n: ba_oe_n};
        src[0] = a_in;
        src[1] = b_in;
    end

    for (genvar d = 0; d < NUM_DIR; d++) begin : g_dir
        xcvr_lane #(.W(DATA_W)) u_lane (
            .clk   (clk),
            .rst_n (rst_n),
            .ctl   (ctl[d]),
            .din   (src[d]),
            .dout  (dst[d]),
            .drv   (dvr[d])
        );
    end

    // Purpose: route lane results to the opposite port.
    always_comb begin
        b_out = dst[0];
        b_drv = dvr[0];
        a_out = dst[1];
        a_drv = dvr[1];
    end
endmodule

// File: rtl/bidir_xcvr_reg_chk.sv
// Module: assertion checker for bidir_xcvr_reg, attached by bind. It watches
// the ports only.
module bidir_xcvr_reg_chk #(
    parameter int DATA_W = 18
) (
    input logic              clk,
    input logic              rst_n,
    input logic [DATA_W-1:0] a_in,
    input logic [DATA_W-1:0] a_out,
    input logic              a_drv,
    input logic [DATA_W-1:0] b_in,
    input logic [DATA_W-1:0] b_out,
    input logic              b_drv,
    input logic              ab_oe_n,
    input logic              ab_le,
    input logic              ab_strobe,
    input logic              ab_strobe_en_n,
    input logic              ba_oe_n,
    input logic              ba_le,
    input logic              ba_strobe,
    input logic              ba_strobe_en_n
);
    // R1: transparency on both directions
    a_r1_transparent_ab: assert property (@(posedge clk) disable iff (!rst_n)
        ab_le |-> (b_out == a_in));
    a_r1_transparent_ba: assert property (@(posedge clk) disable iff (!rst_n)
        ba_le |-> (a_out == b_in));

    // R2: qualified strobe rise captures the input
    a_r2_capture_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !ab_strobe_en_n && ab_strobe && !$past(ab_strobe))
        |=> (ab_le || b_out == $past(a_in)));
    a_r2_capture_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !ba_strobe_en_n && ba_strobe && !$past(ba_strobe))
        |=> (ba_le || a_out == $past(b_in)));

    // R3/R4/R7: without a qualified rise the stored value holds, whatever the other side does
    a_r3_hold_ab: assert property (@(posedge clk) disable iff (!rst_n)
        (!ab_le && !(!ab_strobe_en_n && ab_strobe && !$past(ab_strobe)))
        |=> (ab_le || b_out == $past(b_out)));
    a_r3_hold_ba: assert property (@(posedge clk) disable iff (!rst_n)
        (!ba_le && !(!ba_strobe_en_n && ba_strobe && !$past(ba_strobe)))
        |=> (ba_le || a_out == $past(a_out)));

    // R6: drive enables follow the active-low output enables
    a_r6_drive: assert property (@(posedge clk) disable iff (!rst_n)
        (b_drv == !ab_oe_n) && (a_drv == !ba_oe_n));

    // R8: reset clears storage
    a_r8_reset_clear: assert property (@(posedge clk)
        !rst_n |=> ((ab_le || b_out == '0) && (ba_le || a_out == '0)));
endmodule

bind bidir_xcvr_reg bidir_xcvr_reg_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/test_bidir_xcvr_reg.sv
`timescale 1ns/1ps
module test_bidir_xcvr_reg;
    localparam int W = 18;

    typedef struct packed {
        logic         le;
        logic         stb;
        logic         en_n;
        logic [W-1:0] din;
        logic [W-1:0] exp;
        logic [3:0]   req;
    } vec_t;

    // A-to-B sequence after reset (stored value 0); the expected output is
    // read after the core clock edge that follows the drive.
    localparam vec_t VEC [12] = '{
        '{1'b0, 1'b0, 1'b0, 18'h12345, 18'h00000, 4'd3},  // R3 no rise, stays at reset value
        '{1'b0, 1'b1, 1'b0, 18'h0ABCD, 18'h0ABCD, 4'd2},  // R2 capture on rise
        '{1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h0ABCD, 4'd3},  // R3 strobe held high
        '{1'b0, 1'b0, 1'b0, 18'h3FFFF, 18'h0ABCD, 4'd3},  // R3 falling strobe ignored
        '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h0ABCD, 4'd4},  // R4 enable off
        '{1'b0, 1'b1, 1'b1, 18'h15555, 18'h0ABCD, 4'd4},  // R4 rise while disabled
        '{1'b0, 1'b0, 1'b1, 18'h15555, 18'h0ABCD, 4'd4},  // R4
        '{1'b1, 1'b0, 1'b1, 18'h2AAAA, 18'h2AAAA, 4'd1},  // R1 transparent
        '{1'b1, 1'b1, 1'b0, 18'h00F0F, 18'h00F0F, 4'd1},  // R1 rise does not matter
        '{1'b0, 1'b1, 1'b0, 18'h3FFFF, 18'h00F0F, 4'd5},  // R5 keeps last transparent value
        '{1'b0, 1'b0, 1'b0, 18'h11111, 18'h00F0F, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 18'h22222, 18'h22222, 4'd2}   // R2 capture again
    };

    logic         clk = 1'b0;
    logic         rst_n;
    logic [W-1:0] a_in, a_out, b_in, b_out;
    logic         a_drv, b_drv;
    logic         ab_oe_n, ab_le, ab_strobe, ab_strobe_en_n;
    logic         ba_oe_n, ba_le, ba_strobe, ba_strobe_en_n;

    int total = 0;
    int bad   = 0;

    always #4 clk = ~clk;  // 125 MHz

    bidir_xcvr_reg #(.DATA_W(W)) i_bidir_xcvr_reg (.*);

    task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 8);
        bad++;
        total++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst_n = 1'b0;
        a_in = '0; b_in = '0;
        ab_oe_n = 1'b0; ab_le = 1'b0; ab_strobe = 1'b0; ab_strobe_en_n = 1'b0;
        ba_oe_n = 1'b0; ba_le = 1'b0; ba_strobe = 1'b0; ba_strobe_en_n = 1'b0;
        a_in = 18'h3FFFF; b_in = 18'h3FFFF;
        tick(); tick();
        rst_n = 1'b1;
        tick();
        check("R8 reset b_out", b_out, '0);
        check("R8 reset a_out", a_out, '0);
        check("R9 width", 18'($bits(b_out)), 18'(W));

        // Vector table on A-to-B; B-to-A idles with moving data (R7)
        for (int i = 0; i < 12; i++) begin
            ab_le          = VEC[i].le;
            ab_strobe      = VEC[i].stb;
            ab_strobe_en_n = VEC[i].en_n;
            ab_oe_n        = i[0];
            a_in           = VEC[i].din;
            b_in           = ~VEC[i].din;
            tick();
            check($sformatf("R%0d vec %0d b_out", VEC[i].req, i), b_out, VEC[i].exp);
            check($sformatf("R6 vec %0d b_drv", i), 18'(b_drv), 18'(!ab_oe_n));
            check($sformatf("R7 vec %0d a_out", i), a_out, '0);
        end

        // R7: B-to-A capture leaves A-to-B untouched
        b_in = 18'h1F00F; ba_strobe = 1'b1;
        tick();
        check("R7 ba capture a_out", a_out, 18'h1F00F);
        check("R7 ab unaffected b_out", b_out, 18'h22222);

        // R6: capture while drive is off, then enable drive without changing storage
        ab_oe_n = 1'b1; ab_strobe = 1'b0;
        tick();
        a_in = 18'h33333; ab_strobe = 1'b1;
        tick();
        check("R6 capture while off b_out", b_out, 18'h33333);
        check("R6 drive off b_drv", 18'(b_drv), 18'd0);
        ab_oe_n = 1'b0; a_in = 18'h00001;
        tick();
        check("R6 enable keeps b_out", b_out, 18'h33333);
        check("R6 drive on b_drv", 18'(b_drv), 18'd1);

        // R8: reset mid-operation
        rst_n = 1'b0;
        tick();
        check("R8 mid reset b_out", b_out, '0);
        check("R8 mid reset a_out", a_out, '0);
        rst_n = 1'b1;
        tick();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule